// File: doc/BRIEF.md
# Stretchable External Bus Cycle Controller

This block runs bus cycles on an external memory bus on behalf of a 16-bit internal master. The master makes a one-cycle request that carries an address, a direction, a width (byte or word) and write data. The controller then sequences one external cycle. The first phase is an address phase of fixed length, with the strobe low. The second is a data phase with the strobe high. A 2-bit stretch register lengthens the data phase by zero to three extra bus clocks, so slower devices can coexist with fast internal cycles. The address phase is never lengthened.

On the external side the block drives a low-active byte strobe and address bit 0. Together with the read/write line, these tell the device the width and alignment of each access. For word accesses at an odd address the block exchanges the two byte lanes in both directions. While a cycle is in progress the master sees a hold output. Completion is marked by a single done pulse. A free-running reference tick is produced beside the bus logic, and stretching never disturbs it.

Top module: `ebus_cycle_ctrl`

## Requirements
- R1: The stretch register (written through `cfg_we`/`cfg_stretch`, reset value 0) holds a value S from 0 to 3. Every external cycle keeps `x_e` high for exactly S+1 consecutive clocks.
- R2: Each cycle starts with an address phase of exactly one clock, with `x_cs_n` low and `x_e` low, whatever the stretch value.
- R3: After the clock that accepts `m_req`, `m_hold` is high through the last clock with `x_e` high. In the next clock `m_hold` is low and `m_done` is high for that one clock only.
- R4: `x_doe` is high only while `x_e` is high on a write cycle, and it stays high for every such clock. It is never high in the address phase or when idle.
- R5: `x_cs_n`, `x_rw`, `x_addr`, `x_lstrb` and `x_dout` hold steady from the address phase through the final clock with `x_e` high.
- R6: Read data is taken from `x_din` only in the last clock with `x_e` high, which is the falling edge of the strobe. Values present in earlier data-phase clocks have no effect on `m_rdata`.
- R7: The access type is encoded as {`x_lstrb`, `x_addr[0]`, `x_rw`}, with `x_rw`=1 for a read. A byte access at an even address gives `x_lstrb`=1, and at an odd address gives 0. A word access at an even address gives `x_lstrb`=0, and at an odd address gives 1.
- R8: Lane mapping uses `[15:8]` as the high lane. A word at an even address travels unchanged. A word at an odd address has its halves exchanged on `x_dout` and on the way back to `m_rdata`. A byte write puts `m_wdata[7:0]` on the high lane for an even address and on the low lane for an odd address, with the other lane zero. A byte read returns that lane in `m_rdata[7:0]`, with the upper half zero.
- R9: A stretch value written during a cycle, or in the clock that accepts a request, does not change that cycle. It applies from the next accepted request.
- R10: Whenever `m_hold` is low, the bus idles with `x_cs_n`=1, `x_rw`=1, `x_e`=0 and `x_doe`=0.
- R11: `ref_tick` pulses once every REF_DIV clocks without a break, whether or not a stretched cycle is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the stretch register |
| cfg_stretch | input | SW | New stretch value |
| m_req | input | 1 | One-cycle request, accepted when `m_hold` is low |
| m_addr | input | AW | Byte address |
| m_we | input | 1 | 1 = write, 0 = read |
| m_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit |
| m_wdata | input | 16 | Write data (byte in [7:0] for 8-bit) |
| m_hold | output | 1 | Master must wait while high |
| m_done | output | 1 | One-clock completion pulse |
| m_rdata | output | 16 | Read data, valid from `m_done` |
| x_addr | output | AW | External address |
| x_dout | output | 16 | External write data |
| x_doe | output | 1 | Data bus output enable |
| x_din | input | 16 | External read data |
| x_rw | output | 1 | 1 = read, 0 = write |
| x_lstrb | output | 1 | Low-active byte strobe |
| x_cs_n | output | 1 | Chip select, active low |
| x_e | output | 1 | Data phase strobe |
| ref_tick | output | 1 | Reference clock enable, unaffected by stretch |

## Verification
The bench builds the block with AW=16, SW=2 and REF_DIV=5. A 2-bit stretch field puts all four data-phase lengths within reach, and every one of them is measured. A tick period of five clocks is shorter than the longest cycle, which lasts six clocks including the done clock. This means reference ticks land inside stretched data phases, where an interrupted count would show up as an irregular gap. The bench pairs all eight width/alignment/direction combinations with different stretch values. It drives decoy read data in every data-phase clock except the last.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } bus_st_e;

endpackage

// File: rtl/ebus_lane_codec.sv
module ebus_lane_codec #(
    parameter int DW = 16
) (
    input  logic          odd,
    input  logic          wide,
    input  logic [DW-1:0] wr_word,
    input  logic [DW-1:0] bus_in,
    output logic          lstrb,
    output logic [DW-1:0] bus_out,
    output logic [DW-1:0] rd_word
);
    localparam int BW = DW / 2;

    logic [BW-1:0] hi_in, lo_in;

    assign hi_in = bus_in[DW-1:BW];
    assign lo_in = bus_in[BW-1:0];

    // strobe low for odd byte and for aligned word
    assign lstrb = ~(wide ^ odd);

    always_comb begin
        if (wide) begin
            bus_out = odd ? {wr_word[BW-1:0], wr_word[DW-1:BW]} : wr_word;
            rd_word = odd ? {lo_in, hi_in} : bus_in;
        end else begin
            bus_out = odd ? {{BW{1'b0}}, wr_word[BW-1:0]}
                          : {wr_word[BW-1:0], {BW{1'b0}}};
            rd_word = {{BW{1'b0}}, (odd ? lo_in : hi_in)};
        end
    end

endmodule

// File: rtl/ebus_ref_tick.sv
module ebus_ref_tick #(
    parameter int DIV = 5
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } tick_regs_t;

    tick_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (r_q.cnt == CW'(DIV - 1)) begin
            r_d.cnt  = '0;
            r_d.tick = 1'b1;
        end else begin
            r_d.cnt  = r_q.cnt + 1'b1;
            r_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tick = r_q.tick;

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R11

endmodule

// File: rtl/ebus_cycle_ctrl.sv
module ebus_cycle_ctrl
    import ebus_pkg::*;
#(
    parameter int AW      = 16,
    parameter int SW      = 2,
    parameter int REF_DIV = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [SW-1:0] cfg_stretch,
    input  logic          m_req,
    input  logic [AW-1:0] m_addr,
    input  logic          m_we,
    input  logic          m_wide,
    input  logic [15:0]   m_wdata,
    output logic          m_hold,
    output logic          m_done,
    output logic [15:0]   m_rdata,
    output logic [AW-1:0] x_addr,
    output logic [15:0]   x_dout,
    output logic          x_doe,
    input  logic [15:0]   x_din,
    output logic          x_rw,
    output logic          x_lstrb,
    output logic          x_cs_n,
    output logic          x_e,
    output logic          ref_tick
);
    localparam int MAX_STR = (1 << SW) - 1;

    typedef struct packed {
        bus_st_e       st;
        logic [SW-1:0] cfg;
        logic [SW-1:0] left;
        logic [AW-1:0] addr;
        logic          we;
        logic          wide;
        logic [15:0]   wdata;
        logic [15:0]   rdata;
        logic          done;
    } regs_t;

    regs_t r_d, r_q;

    logic        lane_lstrb;
    logic [15:0] lane_wr, lane_rd;

    ebus_lane_codec #(.DW(16)) u_codec (
        .odd     (r_q.addr[0]),
        .wide    (r_q.wide),
        .wr_word (r_q.wdata),
        .bus_in  (x_din),
        .lstrb   (lane_lstrb),
        .bus_out (lane_wr),
        .rd_word (lane_rd)
    );

    ebus_ref_tick #(.DIV(REF_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (ref_tick)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (cfg_we) r_d.cfg = cfg_stretch;
        unique case (r_q.st)
            ST_IDLE: begin
                if (m_req) begin
                    r_d.st    = ST_ADDR;
                    r_d.addr  = m_addr;
                    r_d.we    = m_we;
                    r_d.wide  = m_wide;
                    r_d.wdata = m_wdata;
                    r_d.left  = r_q.cfg; // snapshot, later writes wait
                end
            end
            ST_ADDR: r_d.st = ST_DATA;
            ST_DATA: begin
                if (r_q.left == '0) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    if (!r_q.we) r_d.rdata = lane_rd; // strobe falling edge
                end else begin
                    r_d.left = r_q.left - 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    logic active;
    assign active  = (r_q.st != ST_IDLE);
    assign m_hold  = active;
    assign m_done  = r_q.done;
    assign m_rdata = r_q.rdata;
    assign x_addr  = r_q.addr;
    assign x_cs_n  = !active;
    assign x_e     = (r_q.st == ST_DATA);
    assign x_rw    = active ? !r_q.we : 1'b1;
    assign x_lstrb = active ? lane_lstrb : 1'b1;
    assign x_doe   = x_e && r_q.we;
    assign x_dout  = r_q.we ? lane_wr : 16'h0000;

    // checker state: length of the current strobe-high run
    logic [SW:0] e_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   e_run_q <= '0;
        else if (x_e) e_run_q <= e_run_q + 1'b1;
        else          e_run_q <= '0;
    end

    AST_E_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        x_e |-> e_run_q <= (SW+1)'(MAX_STR)); // R1

    AST_ADDR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!x_cs_n && !x_e) |=> x_e); // R2

    AST_HOLD_E: assert property (@(posedge clk) disable iff (!rst_n)
        x_e |-> m_hold); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        m_done |=> !m_done); // R3

    AST_DONE_AFTER_E: assert property (@(posedge clk) disable iff (!rst_n)
        m_done |-> $past(x_e) && !x_e); // R3

    AST_DOE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        x_doe |-> x_e && !x_rw && !x_cs_n); // R4

    AST_CTRL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (x_e && !x_cs_n && $past(!x_cs_n)) |->
            $stable(x_rw) && $stable(x_addr) && $stable(x_lstrb) && $stable(x_dout)); // R5

    AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !m_hold |-> x_cs_n && x_rw && !x_e && !x_doe); // R10

endmodule

// File: tb/ebus_cycle_ctrl_tb.sv
module ebus_cycle_ctrl_tb;
    localparam int AW      = 16;
    localparam int SW      = 2;
    localparam int REF_DIV = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [SW-1:0] cfg_stretch = '0;
    logic          m_req = 1'b0;
    logic [AW-1:0] m_addr = '0;
    logic          m_we = 1'b0;
    logic          m_wide = 1'b0;
    logic [15:0]   m_wdata = '0;
    logic          m_hold, m_done;
    logic [15:0]   m_rdata;
    logic [AW-1:0] x_addr;
    logic [15:0]   x_dout;
    logic          x_doe;
    logic [15:0]   x_din = 16'hDEAD;
    logic          x_rw, x_lstrb, x_cs_n, x_e, ref_tick;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ebus_cycle_ctrl #(.AW(AW), .SW(SW), .REF_DIV(REF_DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_stretch(cfg_stretch),
        .m_req(m_req), .m_addr(m_addr), .m_we(m_we), .m_wide(m_wide),
        .m_wdata(m_wdata), .m_hold(m_hold), .m_done(m_done), .m_rdata(m_rdata),
        .x_addr(x_addr), .x_dout(x_dout), .x_doe(x_doe), .x_din(x_din),
        .x_rw(x_rw), .x_lstrb(x_lstrb), .x_cs_n(x_cs_n), .x_e(x_e),
        .ref_tick(ref_tick)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference tick monitor (R11)
    int tick_gap = 0;
    int tick_seen = 0;
    int tick_bad = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            tick_gap++;
            if (ref_tick) begin
                if (tick_seen > 0 && tick_gap != REF_DIV) tick_bad++;
                tick_seen++;
                tick_gap = 0;
            end
        end
    end

    task automatic set_stretch(input int v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_stretch = SW'(v);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(x_cs_n && x_rw && !x_e && !x_doe && !m_hold && !m_done, "R10 reset idle",
              {26'd0, x_cs_n, x_rw, x_e, x_doe, m_hold, m_done}, 32'h30);
    endtask

    // One external cycle; checks its own timing, encoding and data (R1-R8)
    task automatic do_access(input logic we, input logic wide, input logic [15:0] addr,
                             input logic [15:0] wdata, input logic [15:0] rdval,
                             input int exp_s, input int mid_cfg, input string tag);
        int n_a = 0, n_e = 0, guard = 0;
        int enc_bad = 0, lane_bad = 0, hold_bad = 0, stab_bad = 0, doe_bad = 0;
        bit seen_done = 1'b0;
        bit cfg_sent = 1'b0;
        logic exp_lstrb;
        logic [15:0] exp_dout, exp_rd;
        exp_lstrb = wide ? addr[0] : ~addr[0];
        if (wide) begin
            exp_dout = addr[0] ? {wdata[7:0], wdata[15:8]} : wdata;
            exp_rd   = addr[0] ? {rdval[7:0], rdval[15:8]} : rdval;
        end else begin
            exp_dout = addr[0] ? {8'h00, wdata[7:0]} : {wdata[7:0], 8'h00};
            exp_rd   = addr[0] ? {8'h00, rdval[7:0]} : {8'h00, rdval[15:8]};
        end
        @(negedge clk);
        m_req = 1'b1; m_we = we; m_wide = wide; m_addr = addr; m_wdata = wdata;
        x_din = 16'hDEAD;
        @(negedge clk);
        m_req = 1'b0; m_addr = ~addr; m_wdata = ~wdata; m_wide = ~wide; m_we = ~we;
        while (!seen_done && guard < 20) begin
            guard++;
            cfg_we = 1'b0;
            if (m_done) begin
                seen_done = 1'b1;
                if (m_hold) hold_bad++;
                check(x_cs_n && x_rw && !x_e && !x_doe, {"R10 idle after ", tag},
                      {28'd0, x_cs_n, x_rw, x_e, x_doe}, 32'hC);
            end else begin
                if (!m_hold) hold_bad++;
                if (x_cs_n) stab_bad++;
                if (x_lstrb !== exp_lstrb || x_addr !== addr || x_rw !== !we) enc_bad++;
                if (we && x_dout !== exp_dout) lane_bad++;
                if (!x_e) begin
                    n_a++;
                    if (x_doe) doe_bad++;
                    if (mid_cfg >= 0 && !cfg_sent) begin
                        cfg_we = 1'b1;
                        cfg_stretch = SW'(mid_cfg);
                        cfg_sent = 1'b1;
                    end
                end else begin
                    n_e++;
                    if (x_doe !== we) doe_bad++;
                    x_din = (n_e == exp_s + 1) ? rdval : (16'hDEAD ^ 16'(n_e));
                end
            end
            if (!seen_done) @(negedge clk);
        end
        cfg_we = 1'b0;
        check(seen_done, {"R3 done seen ", tag}, 32'(seen_done), 32'd1);
        check(n_a == 1, {"R2 address phase ", tag}, 32'(n_a), 32'd1);
        check(n_e == exp_s + 1, {"R1/R9 strobe length ", tag}, 32'(n_e), 32'(exp_s + 1));
        check(hold_bad == 0, {"R3 hold ", tag}, 32'(hold_bad), 32'd0);
        check(stab_bad == 0 && enc_bad == 0, {"R5/R7 control and encoding ", tag},
              32'(stab_bad + enc_bad), 32'd0);
        check(doe_bad == 0, {"R4 output enable ", tag}, 32'(doe_bad), 32'd0);
        if (we) check(lane_bad == 0, {"R8 write lanes ", tag}, 32'(lane_bad), 32'd0);
        else    check(m_rdata === exp_rd, {"R6/R8 read data ", tag}, 32'(m_rdata), 32'(exp_rd));
        @(negedge clk);
        check(!m_done && !m_hold, {"R3 single done ", tag}, {30'd0, m_done, m_hold}, 32'd0);
    endtask

    task automatic t_types;
        set_stretch(0);
        do_access(1'b0, 1'b0, 16'h1230, 16'h0000, 16'hA55A, 0, -1, "R7 byte rd even");
        do_access(1'b0, 1'b0, 16'h1231, 16'h0000, 16'hA55A, 0, -1, "R7 byte rd odd");
        set_stretch(1);
        do_access(1'b1, 1'b0, 16'h2000, 16'h00C3, 16'h0000, 1, -1, "R7 byte wr even");
        do_access(1'b1, 1'b0, 16'h2001, 16'h003C, 16'h0000, 1, -1, "R7 byte wr odd");
        set_stretch(2);
        do_access(1'b0, 1'b1, 16'h4444, 16'h0000, 16'h1357, 2, -1, "R7 word rd even");
        do_access(1'b0, 1'b1, 16'h4445, 16'h0000, 16'h1357, 2, -1, "R8 word rd odd");
        set_stretch(3);
        do_access(1'b1, 1'b1, 16'h8000, 16'hBEEF, 16'h0000, 3, -1, "R7 word wr even");
        do_access(1'b1, 1'b1, 16'h8003, 16'hBEEF, 16'h0000, 3, -1, "R8 word wr odd");
    endtask

    task automatic t_mid_change;
        set_stretch(3);
        do_access(1'b0, 1'b1, 16'h0102, 16'h0000, 16'h2468, 3, 0, "R9 change in cycle");
        do_access(1'b0, 1'b1, 16'h0104, 16'h0000, 16'h8642, 0, -1, "R9 next cycle");
        set_stretch(2);
        do_access(1'b1, 1'b0, 16'h0107, 16'h0099, 16'h0000, 2, 1, "R9 change 2 to 1");
        do_access(1'b1, 1'b0, 16'h0108, 16'h0077, 16'h0000, 1, -1, "R9 applied 1");
    endtask

    task automatic t_ref_tick;
        set_stretch(3);
        do_access(1'b0, 1'b0, 16'h0010, 16'h0000, 16'h55AA, 3, -1, "R11 background");
        repeat (12) @(negedge clk);
        check(tick_seen > 4 && tick_bad == 0, "R11 reference tick spacing",
              32'(tick_bad), 32'd0);
    endtask

    initial begin
        t_reset;
        t_types;
        t_mid_change;
        t_ref_tick;
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule